// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block decides whether loading a segment register is allowed under a four-ring privilege scheme. Each request names the register being loaded and supplies the decoded descriptor: whether it is present, whether it is code or data, its readable, writable and conforming attributes, and its descriptor level. It also supplies the current level of the running task and the level requested by the selector. Levels are 2-bit values. Level 0 is the most privileged and level 3 the least.

One cycle after the request strobe, the unit returns either a grant or a fault. A fault comes with a fault vector code. The unit also returns the privilege level that holds after the load. With protection switched off, every load is granted. With protection on, the rules depend on the register being loaded:

- A data or extra register load compares the descriptor level with the weaker of the current and requested levels.
- A stack register load needs all three levels to be equal.
- Code register loads have their own rules for conforming and non-conforming code.

Top module: `seg_priv_check`

## Requirements
- R1: When `prot_en` is 0, every request is granted with no check, and `new_pl` equals `cur_pl`.
- R2: With `tgt_sel`=0 (data/extra) and a present data descriptor, the load is granted exactly when `dsc_pl` >= max(`cur_pl`, `req_pl`). Otherwise it faults with vector 13.
- R3: With `tgt_sel`=1 (stack) and a present descriptor, the load is granted only if the descriptor is data (`dsc_is_code`=0), writable, and `cur_pl`, `req_pl` and `dsc_pl` are all equal. Otherwise it faults with vector 13.
- R4: With `tgt_sel`=0, a present readable conforming code descriptor is granted at any combination of levels. A non-readable code descriptor faults with vector 13. A readable non-conforming code descriptor follows the level test of R2.
- R5: With `tgt_sel`=2 (code), a present descriptor with `dsc_is_code`=0 faults with vector 13. A non-conforming code descriptor is granted only if `dsc_pl` == `cur_pl` and `req_pl` <= `cur_pl`. Otherwise it faults with vector 13.
- R6: With `tgt_sel`=2, a present conforming code descriptor is granted when `dsc_pl` <= `cur_pl`, and faults with vector 13 otherwise. On every grant, `new_pl` equals the requesting `cur_pl`, never `dsc_pl`.
- R7: In protected mode, a descriptor with `dsc_present`=0 faults with vector 12 for `tgt_sel`=1 and with vector 11 for `tgt_sel`=0 or 2. The presence check takes precedence over the type and level checks.
- R8: In protected mode, `tgt_sel`=3 is a reserved select and faults with vector 13.
- R9: The result appears on the cycle after `req_valid`, with `rsp_valid`=1. `grant` and `fault` are never both 1, and `fault_vec` is 0 unless `fault` is 1. On a cycle with no response, `rsp_valid`, `grant` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| prot_en | input | 1 | Protection enabled |
| cur_pl | input | 2 | Current privilege level |
| req_pl | input | 2 | Requested privilege level from the selector |
| tgt_sel | input | 2 | Register loaded: 0 data/extra, 1 stack, 2 code, 3 reserved |
| dsc_present | input | 1 | Descriptor valid and present |
| dsc_is_code | input | 1 | Descriptor is a code segment |
| dsc_readable | input | 1 | Code segment is readable |
| dsc_writable | input | 1 | Data segment is writable |
| dsc_conforming | input | 1 | Code segment is conforming |
| dsc_pl | input | 2 | Descriptor privilege level |
| rsp_valid | output | 1 | Result valid |
| grant | output | 1 | Load allowed |
| fault | output | 1 | Load refused |
| fault_vec | output | 8 | Fault vector code (11, 12 or 13), 0 when no fault |
| new_pl | output | 2 | Privilege level in force after the load |

## Verification
The hardest case to reach from the ports is a load that passes every type and presence check but fails a single level comparison by exactly one step. Examples are a stack load where only `req_pl` differs, or a data load where `dsc_pl` sits exactly at max(`cur_pl`, `req_pl`) or one below it. Uniform random stimulus rarely produces these combinations. The bench therefore drives directed edge pairs for each rule. It then runs seeded random requests in which roughly half of the descriptors are forced to be present, well-typed and level-equal, and only one field is perturbed.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;

   typedef enum logic [1:0] {
      TGT_DATA  = 2'd0,
      TGT_STACK = 2'd1,
      TGT_CODE  = 2'd2,
      TGT_RSVD  = 2'd3
   } tgt_e;

   typedef struct packed {
      logic present;
      logic is_code;
      logic readable;
      logic writable;
      logic conforming;
   } dsc_attr_t;

   typedef struct packed {
      logic dpl_ge_eff;   // descriptor no more privileged than max(cpl,rpl)
      logic all_eq;       // cpl == rpl == dpl
      logic dpl_eq_cpl;
      logic rpl_le_cpl;
      logic dpl_le_cpl;
   } lvl_flags_t;

endpackage

// File: rtl/seg_level_cmp.sv
module seg_level_cmp
   import seg_priv_pkg::*;
#(
   parameter int PL_W        = 2,
   parameter bit MAX_BY_MUX  = 1'b1
) (
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] rpl,
   input  logic [PL_W-1:0] dpl,
   output lvl_flags_t      flags
);

   if (PL_W < 1) begin : g_bad_w
      $error("seg_level_cmp: PL_W must be at least 1");
   end

   logic ge_eff;

   if (MAX_BY_MUX) begin : g_max_mux
      logic [PL_W-1:0] eff_pl;
      always_comb eff_pl = (cpl > rpl) ? cpl : rpl;
      always_comb ge_eff = (dpl >= eff_pl);
   end else begin : g_max_pair
      always_comb ge_eff = (dpl >= cpl) && (dpl >= rpl);
   end

   always_comb begin
      flags.dpl_ge_eff = ge_eff;
      flags.all_eq     = (cpl == rpl) && (rpl == dpl);
      flags.dpl_eq_cpl = (dpl == cpl);
      flags.rpl_le_cpl = (rpl <= cpl);
      flags.dpl_le_cpl = (dpl <= cpl);
   end

endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
   import seg_priv_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int GP_VEC = 13,
   parameter int NP_VEC = 11,
   parameter int SS_VEC = 12
) (
   input  logic             prot_en,
   input  tgt_e             tgt,
   input  dsc_attr_t        attr,
   input  lvl_flags_t       lvl,
   output logic             ok,
   output logic [VEC_W-1:0] vec
);

   localparam logic [VEC_W-1:0] GP_C = VEC_W'(GP_VEC);
   localparam logic [VEC_W-1:0] NP_C = VEC_W'(NP_VEC);
   localparam logic [VEC_W-1:0] SS_C = VEC_W'(SS_VEC);

   if (GP_VEC >= (1 << VEC_W) || NP_VEC >= (1 << VEC_W) || SS_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("seg_rule_eval: fault vector does not fit in VEC_W");
   end
   if (GP_VEC == 0 || NP_VEC == 0 || SS_VEC == 0) begin : g_zero_vec
      $error("seg_rule_eval: fault vectors must be nonzero");
   end

   always_comb begin
      ok  = 1'b0;
      vec = GP_C;
      if (!prot_en) begin
         ok  = 1'b1;
      end else if (tgt == TGT_RSVD) begin
         vec = GP_C;
      end else if (!attr.present) begin
         vec = (tgt == TGT_STACK) ? SS_C : NP_C;
      end else begin
         case (tgt)
            TGT_DATA: begin
               if (attr.is_code && !attr.readable)
                  ok = 1'b0;
               else if (attr.is_code && attr.conforming)
                  ok = 1'b1;
               else
                  ok = lvl.dpl_ge_eff;
            end
            TGT_STACK: begin
               ok = !attr.is_code && attr.writable && lvl.all_eq;
            end
            TGT_CODE: begin
               if (!attr.is_code)
                  ok = 1'b0;
               else if (attr.conforming)
                  ok = lvl.dpl_le_cpl;
               else
                  ok = lvl.dpl_eq_cpl && lvl.rpl_le_cpl;
            end
            default: ok = 1'b0;
         endcase
      end
      if (ok) vec = '0;
   end

endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
   import seg_priv_pkg::*;
#(
   parameter int PL_W       = 2,
   parameter int VEC_W      = 8,
   parameter int GP_VEC     = 13,
   parameter int NP_VEC     = 11,
   parameter int SS_VEC     = 12,
   parameter bit MAX_BY_MUX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             prot_en,
   input  logic [PL_W-1:0]  cur_pl,
   input  logic [PL_W-1:0]  req_pl,
   input  logic [1:0]       tgt_sel,
   input  logic             dsc_present,
   input  logic             dsc_is_code,
   input  logic             dsc_readable,
   input  logic             dsc_writable,
   input  logic             dsc_conforming,
   input  logic [PL_W-1:0]  dsc_pl,
   output logic             rsp_valid,
   output logic             grant,
   output logic             fault,
   output logic [VEC_W-1:0] fault_vec,
   output logic [PL_W-1:0]  new_pl
);

   localparam logic [VEC_W-1:0] GP_C = VEC_W'(GP_VEC);
   localparam logic [VEC_W-1:0] NP_C = VEC_W'(NP_VEC);
   localparam logic [VEC_W-1:0] SS_C = VEC_W'(SS_VEC);

   dsc_attr_t        attr;
   lvl_flags_t       lvl;
   logic             dec_ok;
   logic [VEC_W-1:0] dec_vec;

   always_comb begin
      attr.present    = dsc_present;
      attr.is_code    = dsc_is_code;
      attr.readable   = dsc_readable;
      attr.writable   = dsc_writable;
      attr.conforming = dsc_conforming;
   end

   seg_level_cmp #(
      .PL_W       (PL_W),
      .MAX_BY_MUX (MAX_BY_MUX)
   ) u_cmp (
      .cpl   (cur_pl),
      .rpl   (req_pl),
      .dpl   (dsc_pl),
      .flags (lvl)
   );

   seg_rule_eval #(
      .VEC_W  (VEC_W),
      .GP_VEC (GP_VEC),
      .NP_VEC (NP_VEC),
      .SS_VEC (SS_VEC)
   ) u_eval (
      .prot_en (prot_en),
      .tgt     (tgt_e'(tgt_sel)),
      .attr    (attr),
      .lvl     (lvl),
      .ok      (dec_ok),
      .vec     (dec_vec)
   );

   // Result register: one cycle after the strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         grant     <= 1'b0;
         fault     <= 1'b0;
         fault_vec <= '0;
         new_pl    <= '0;
      end else begin
         rsp_valid <= req_valid;
         grant     <= req_valid && dec_ok;
         fault     <= req_valid && !dec_ok;
         fault_vec <= (req_valid && !dec_ok) ? dec_vec : '0;
         if (req_valid) new_pl <= cur_pl;
      end
   end

   // R9: grant and fault exclusive
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && fault));

   // R9: vector only alongside fault
   a_r9_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> (fault_vec == '0));

   // R9: no strobe, no response
   a_r9_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !grant && !fault));

   // R1: real mode grants everything
   a_r1_real_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_en) |=> (grant && new_pl == $past(cur_pl)));

   // R3: unequal stack levels fault
   a_r3_stack_eq: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && tgt_sel == 2'd1 && dsc_present && (cur_pl != dsc_pl))
      |=> (fault && fault_vec == GP_C));

   // R6: conforming code keeps caller level
   a_r6_conf_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && tgt_sel == 2'd2 && dsc_present && dsc_is_code &&
       dsc_conforming && (dsc_pl <= cur_pl))
      |=> (grant && new_pl == $past(cur_pl)));

   // R7: missing stack descriptor raises the stack vector
   a_r7_stack_np: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && tgt_sel == 2'd1 && !dsc_present)
      |=> (fault && fault_vec == SS_C));

   // R7: missing data or code descriptor raises the not-present vector
   a_r7_other_np: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && (tgt_sel == 2'd0 || tgt_sel == 2'd2) && !dsc_present)
      |=> (fault && fault_vec == NP_C));

endmodule

// File: tb/seg_priv_check_test.sv
module seg_priv_check_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid, prot_en;
   logic [1:0] cur_pl, req_pl, tgt_sel, dsc_pl;
   logic       dsc_present, dsc_is_code, dsc_readable, dsc_writable, dsc_conforming;
   logic       rsp_valid, grant, fault;
   logic [7:0] fault_vec;
   logic [1:0] new_pl;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   seg_priv_check uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_en(prot_en),
      .cur_pl(cur_pl), .req_pl(req_pl), .tgt_sel(tgt_sel),
      .dsc_present(dsc_present), .dsc_is_code(dsc_is_code),
      .dsc_readable(dsc_readable), .dsc_writable(dsc_writable),
      .dsc_conforming(dsc_conforming), .dsc_pl(dsc_pl),
      .rsp_valid(rsp_valid), .grant(grant), .fault(fault),
      .fault_vec(fault_vec), .new_pl(new_pl)
   );

   // Expected vector (0 means grant), from the requirements
   function automatic logic [7:0] exp_vec(logic pe, logic [1:0] c, logic [1:0] r,
         logic [1:0] t, logic p, logic ic, logic rd, logic wr, logic cf, logic [1:0] d);
      logic [1:0] mx;
      mx = (c > r) ? c : r;
      if (!pe) return 8'd0;
      if (t == 2'd3) return 8'd13;
      if (!p) return (t == 2'd1) ? 8'd12 : 8'd11;
      case (t)
         2'd0: begin
            if (ic && !rd) return 8'd13;
            if (ic && cf) return 8'd0;
            return (d >= mx) ? 8'd0 : 8'd13;
         end
         2'd1: return (!ic && wr && c == r && r == d) ? 8'd0 : 8'd13;
         default: begin
            if (!ic) return 8'd13;
            if (cf) return (d <= c) ? 8'd0 : 8'd13;
            return (d == c && r <= c) ? 8'd0 : 8'd13;
         end
      endcase
   endfunction

   function automatic string tag_of(logic pe, logic [1:0] t, logic p, logic ic);
      if (!pe) return "R1";
      if (t == 2'd3) return "R8";
      if (!p) return "R7";
      if (t == 2'd1) return "R3";
      if (t == 2'd0) return ic ? "R4" : "R2";
      return ic ? "R6" : "R5";
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic req(logic pe, logic [1:0] c, logic [1:0] r, logic [1:0] t,
         logic p, logic ic, logic rd, logic wr, logic cf, logic [1:0] d);
      logic [7:0] ev;
      string tg;
      ev = exp_vec(pe, c, r, t, p, ic, rd, wr, cf, d);
      tg = tag_of(pe, t, p, ic);
      @(negedge clk);
      req_valid = 1'b1; prot_en = pe; cur_pl = c; req_pl = r; tgt_sel = t;
      dsc_present = p; dsc_is_code = ic; dsc_readable = rd; dsc_writable = wr;
      dsc_conforming = cf; dsc_pl = d;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9", "rsp_valid", int'(rsp_valid), 1);
      check(tg, "grant", int'(grant), int'(ev == 8'd0));
      check(tg, "fault", int'(fault), int'(ev != 8'd0));
      check(tg, "fault_vec", int'(fault_vec), int'(ev));
      if (ev == 8'd0) check((t == 2'd2) ? "R6" : tg, "new_pl", int'(new_pl), int'(c));
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      rst_n = 1'b0; req_valid = 1'b0; prot_en = 1'b0; cur_pl = '0; req_pl = '0;
      tgt_sel = '0; dsc_present = 1'b0; dsc_is_code = 1'b0; dsc_readable = 1'b0;
      dsc_writable = 1'b0; dsc_conforming = 1'b0; dsc_pl = '0;
      repeat (3) @(negedge clk);
      check("R9", "reset rsp_valid", int'(rsp_valid), 0);
      check("R9", "reset grant", int'(grant), 0);
      check("R9", "reset fault", int'(fault), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "idle rsp_valid", int'(rsp_valid), 0);

      // R1: real mode, even a missing descriptor
      req(0, 2'd3, 2'd3, 2'd1, 0, 1, 0, 0, 0, 2'd0);
      req(0, 2'd1, 2'd0, 2'd3, 1, 0, 0, 0, 0, 2'd2);
      // R2: edge at max(cpl,rpl) and one below
      req(1, 2'd1, 2'd2, 2'd0, 1, 0, 1, 1, 0, 2'd2);
      req(1, 2'd1, 2'd2, 2'd0, 1, 0, 1, 1, 0, 2'd1);
      req(1, 2'd3, 2'd0, 2'd0, 1, 0, 0, 0, 0, 2'd2);
      // R3: stack rules
      req(1, 2'd2, 2'd2, 2'd1, 1, 0, 0, 1, 0, 2'd2);
      req(1, 2'd2, 2'd1, 2'd1, 1, 0, 0, 1, 0, 2'd2);
      req(1, 2'd2, 2'd2, 2'd1, 1, 0, 0, 0, 0, 2'd2);
      req(1, 2'd0, 2'd0, 2'd1, 1, 1, 1, 1, 0, 2'd0);
      // R4: code into data register
      req(1, 2'd3, 2'd3, 2'd0, 1, 1, 1, 0, 1, 2'd0);
      req(1, 2'd0, 2'd0, 2'd0, 1, 1, 0, 0, 1, 2'd3);
      req(1, 2'd3, 2'd3, 2'd0, 1, 1, 1, 0, 0, 2'd0);
      // R5: non-conforming code target
      req(1, 2'd1, 2'd1, 2'd2, 1, 1, 0, 0, 0, 2'd1);
      req(1, 2'd1, 2'd2, 2'd2, 1, 1, 0, 0, 0, 2'd1);
      req(1, 2'd1, 2'd0, 2'd2, 1, 0, 1, 1, 0, 2'd1);
      // R6: conforming code target keeps caller level
      req(1, 2'd3, 2'd3, 2'd2, 1, 1, 1, 0, 1, 2'd0);
      req(1, 2'd1, 2'd1, 2'd2, 1, 1, 0, 0, 1, 2'd2);
      // R7: presence precedence
      req(1, 2'd0, 2'd3, 2'd0, 0, 1, 0, 0, 0, 2'd0);
      req(1, 2'd1, 2'd1, 2'd1, 0, 0, 0, 1, 0, 2'd1);
      req(1, 2'd1, 2'd1, 2'd2, 0, 1, 0, 0, 0, 2'd1);
      // R8: reserved select
      req(1, 2'd0, 2'd0, 2'd3, 1, 0, 1, 1, 0, 2'd0);

      // Seeded random, half near-legal with one field perturbed
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] c, r, d, t;
         logic pe, p, ic, rd, wr, cf;
         t  = 2'($urandom_range(0, 3));
         pe = ($urandom_range(0, 7) != 0);
         c  = 2'($urandom_range(0, 3));
         r  = 2'($urandom_range(0, 3));
         d  = 2'($urandom_range(0, 3));
         p  = ($urandom_range(0, 5) != 0);
         ic = 1'($urandom_range(0, 1));
         rd = 1'($urandom_range(0, 1));
         wr = 1'($urandom_range(0, 1));
         cf = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 1) == 1) begin
            r = c; d = c; p = 1'b1;
            ic = (t == 2'd2); wr = 1'b1; rd = 1'b1;
            case ($urandom_range(0, 2))
               0: r = 2'($urandom_range(0, 3));
               1: d = 2'($urandom_range(0, 3));
               default: ic = ~ic;
            endcase
         end
         req(pe, c, r, t, p, ic, rd, wr, cf, d);
      end

      @(negedge clk);
      check("R9", "rsp_valid after last", int'(rsp_valid), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule